// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pull-up Control

This block is an eight-pin (by default) general-purpose I/O port. Software sees it through a small register bus with a write strobe, a read strobe, an address and a data word. Three addresses select three per-pin bit vectors. The direction vector chooses input or output for each pin. The level vector serves two purposes. On an output pin it sets the driven value. On an input pin it requests the pull-up. The third address reads the sampled pad state. A write to that third address inverts the matching level bits.

Each pin has three outputs toward the pad ring: drive enable, drive value and pull-up enable. A shared pull-up-off input blocks every pull-up at once. A shared sleep input clamps the input sampling path to zero. Pad input passes through a chain of flip-flops before it is readable. The active-low reset is asynchronous. It tri-states every pin at once, even when no clock edge arrives.

Top module: `bidir_gpio_port`

## Requirements
- R1: While rst_n is low, and without any clock edge, pad_oe, pad_out and pad_pu are all zero. The direction and level vectors read back zero after release.
- R2: A write with bus_addr = 1 loads bus_wdata into the direction vector on that clock edge. A direction bit of 1 sets the matching pad_oe bit. A read at address 1 returns the vector.
- R3: A write with bus_addr = 2 loads the level vector, and a read at address 2 returns it. A pin with direction 1 drives pad_out equal to its level bit. A pin with direction 0 drives pad_out = 0.
- R4: pad_pu of a pin is 1 only when its direction bit is 0, its level bit is 1 and pullup_off is 0.
- R5: While pullup_off is 1, every pad_pu bit is 0, whatever the level bits hold.
- R6: A read at address 0 returns pad_in as it was sampled two clock edges earlier. The value applied before the first edge is not yet visible after one edge.
- R7: While sleep_req is 1, the synchronizer takes zero in place of pad_in. After two edges with sleep asserted, a read at address 0 returns zero.
- R8: A write at address 0 inverts each level bit whose bus_wdata bit is 1 and leaves the others unchanged.
- R9: bus_rdata is zero when bus_rd is 0 and when bus_addr = 3. A write at address 3 changes neither the direction vector nor the level vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (2) | Register select: 0 pin state/toggle, 1 direction, 2 level |
| bus_wdata | input | W (8) | Write data |
| bus_rdata | output | W (8) | Read data, zero when not reading |
| pad_in | input | W (8) | Raw pad input levels |
| pullup_off | input | 1 | Global pull-up disable |
| sleep_req | input | 1 | Sleep: clamps the input path to zero |
| pad_oe | output | W (8) | Per-pin drive enable |
| pad_out | output | W (8) | Per-pin drive value |
| pad_pu | output | W (8) | Per-pin pull-up enable |

## Verification
If the direction or level vector is corrupted, pad_oe, pad_out or pad_pu show it after the next clock edge. A read at address 1 or 2 shows it on the same cycle as the read. A synchronizer stage that is missing, or one too many, moves pin reads by one cycle. Reads that step through the two-edge window expose it on the first or second read after pad_in changes. A toggle that overwrites instead of inverting shows on both pad_out and pad_pu one edge after the write.

// File: rtl/bidir_gpio_port_pkg.sv
package bidir_gpio_port_pkg;
   // register selected by the current bus address
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_PIN  = 2'd1,
      SEL_DIR  = 2'd2,
      SEL_LVL  = 2'd3
   } reg_sel_e;

   localparam int DEF_W       = 8;
   localparam int DEF_ADDR_W  = 2;
   localparam int DEF_STAGES  = 2;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import bidir_gpio_port_pkg::*;
#(
   parameter int ADDR_W   = 2,
   parameter int PIN_ADDR = 0,
   parameter int DIR_ADDR = 1,
   parameter int LVL_ADDR = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   localparam logic [ADDR_W-1:0] PIN_A = ADDR_W'(PIN_ADDR);
   localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(DIR_ADDR);
   localparam logic [ADDR_W-1:0] LVL_A = ADDR_W'(LVL_ADDR);

   always_comb begin
      if (addr == PIN_A)      sel = SEL_PIN;
      else if (addr == DIR_A) sel = SEL_DIR;
      else if (addr == LVL_A) sel = SEL_LVL;
      else                    sel = SEL_NONE;
   end
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
   import bidir_gpio_port_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  reg_sel_e     sel,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] lvl_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
      end else if (wr_en && sel == SEL_DIR) begin
         dir_q <= wdata;
      end
   end

   // level bits: plain load, or selective inversion through the pin address
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_LVL: lvl_q <= wdata;
            SEL_PIN: lvl_q <= lvl_q ^ wdata;
            default: lvl_q <= lvl_q;
         endcase
      end
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sleep,
   input  logic [W-1:0] pad_i,
   output logic [W-1:0] pin_q
);
   localparam int CHAIN_W = STAGES * W;

   logic [W-1:0]       gated;
   logic [CHAIN_W-1:0] chain;

   assign gated = sleep ? '0 : pad_i;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= gated;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[CHAIN_W-W-1:0], gated};
         end
      end
   endgenerate

   assign pin_q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
   parameter int W         = 8,
   parameter bit MASK_OUT  = 1'b1
) (
   input  logic [W-1:0] dir_q,
   input  logic [W-1:0] lvl_q,
   input  logic         pu_off,
   output logic [W-1:0] oe,
   output logic [W-1:0] dout,
   output logic [W-1:0] pu
);
   generate
      for (genvar b = 0; b < W; b++) begin : g_pin
         assign oe[b] = dir_q[b];
         assign pu[b] = ~dir_q[b] & lvl_q[b] & ~pu_off;
         if (MASK_OUT) begin : g_masked
            assign dout[b] = dir_q[b] & lvl_q[b];
         end else begin : g_raw
            assign dout[b] = lvl_q[b];
         end
      end
   endgenerate
endmodule

// File: rtl/bidir_gpio_port.sv
module bidir_gpio_port
   import bidir_gpio_port_pkg::*;
#(
   parameter int W        = DEF_W,
   parameter int ADDR_W   = DEF_ADDR_W,
   parameter int STAGES   = DEF_STAGES,
   parameter int PIN_ADDR = 0,
   parameter int DIR_ADDR = 1,
   parameter int LVL_ADDR = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [W-1:0]      bus_wdata,
   output logic [W-1:0]      bus_rdata,
   input  logic [W-1:0]      pad_in,
   input  logic              pullup_off,
   input  logic              sleep_req,
   output logic [W-1:0]      pad_oe,
   output logic [W-1:0]      pad_out,
   output logic [W-1:0]      pad_pu
);
   localparam int NUM_ADDR = 1 << ADDR_W;

   generate
      if (W < 1) begin : g_bad_w
         $error("bidir_gpio_port: W must be at least 1");
      end
      if (STAGES < 2) begin : g_bad_stages
         $error("bidir_gpio_port: STAGES must be at least 2");
      end
      if (PIN_ADDR == DIR_ADDR || PIN_ADDR == LVL_ADDR || DIR_ADDR == LVL_ADDR) begin : g_bad_map
         $error("bidir_gpio_port: register addresses must differ");
      end
      if (PIN_ADDR >= NUM_ADDR || DIR_ADDR >= NUM_ADDR || LVL_ADDR >= NUM_ADDR) begin : g_bad_range
         $error("bidir_gpio_port: register address outside ADDR_W");
      end
   endgenerate

   reg_sel_e     sel;
   logic [W-1:0] dir_q;
   logic [W-1:0] lvl_q;
   logic [W-1:0] pin_sync;

   gpio_addr_dec #(
      .ADDR_W  (ADDR_W),
      .PIN_ADDR(PIN_ADDR),
      .DIR_ADDR(DIR_ADDR),
      .LVL_ADDR(LVL_ADDR)
   ) dec_i (
      .addr(bus_addr),
      .sel (sel)
   );

   gpio_ctrl_regs #(.W(W)) regs_i (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(bus_wr),
      .sel  (sel),
      .wdata(bus_wdata),
      .dir_q(dir_q),
      .lvl_q(lvl_q)
   );

   gpio_in_sync #(.W(W), .STAGES(STAGES)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .sleep(sleep_req),
      .pad_i(pad_in),
      .pin_q(pin_sync)
   );

   gpio_pad_ctrl #(.W(W), .MASK_OUT(1'b1)) pads_i (
      .dir_q (dir_q),
      .lvl_q (lvl_q),
      .pu_off(pullup_off),
      .oe    (pad_oe),
      .dout  (pad_out),
      .pu    (pad_pu)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (sel)
            SEL_PIN: bus_rdata = pin_sync;
            SEL_DIR: bus_rdata = dir_q;
            SEL_LVL: bus_rdata = lvl_q;
            default: bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/bidir_gpio_port_chk.sv
module bidir_gpio_port_chk #(
   parameter int W        = 8,
   parameter int ADDR_W   = 2,
   parameter int STAGES   = 2,
   parameter int PIN_ADDR = 0,
   parameter int DIR_ADDR = 1,
   parameter int LVL_ADDR = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [W-1:0]      bus_wdata,
   input logic [W-1:0]      bus_rdata,
   input logic [W-1:0]      pad_in,
   input logic              pullup_off,
   input logic              sleep_req,
   input logic [W-1:0]      pad_oe,
   input logic [W-1:0]      pad_out,
   input logic [W-1:0]      pad_pu,
   input logic [W-1:0]      pin_sync,
   input logic [W-1:0]      lvl_q
);
   localparam logic [ADDR_W-1:0] PIN_A = ADDR_W'(PIN_ADDR);
   localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(DIR_ADDR);
   localparam logic [ADDR_W-1:0] LVL_A = ADDR_W'(LVL_ADDR);

   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R1
   always @(negedge clk) begin
      if (rst_n == 1'b0) begin
         rst_tristate_chk: assert (pad_oe == '0 && pad_out == '0 && pad_pu == '0);
      end
   end

   // R2
   dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DIR_A) |=> pad_oe == $past(bus_wdata));

   // R3
   lvl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == LVL_A) |=> lvl_q == $past(bus_wdata));

   // R3
   in_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & ~pad_oe) == '0);

   // R4
   pu_input_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_oe) == '0);

   // R5
   pu_global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pullup_off |-> pad_pu == '0);

   generate
      if (STAGES == 2) begin : g_two_stage
         // R6
         pin_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd3) |-> pin_sync == $past(sleep_req ? '0 : pad_in, 2));
      end
   endgenerate

   // R7
   sleep_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && $past(sleep_req) && $past(sleep_req, 2)) |-> pin_sync == '0);

   // R8
   pin_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == PIN_A) |=> lvl_q == ($past(lvl_q) ^ $past(bus_wdata)));

   // R9
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == '0);
endmodule

bind bidir_gpio_port bidir_gpio_port_chk #(
   .W       (W),
   .ADDR_W  (ADDR_W),
   .STAGES  (STAGES),
   .PIN_ADDR(PIN_ADDR),
   .DIR_ADDR(DIR_ADDR),
   .LVL_ADDR(LVL_ADDR)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_in    (pad_in),
   .pullup_off(pullup_off),
   .sleep_req (sleep_req),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out),
   .pad_pu    (pad_pu),
   .pin_sync  (pin_sync),
   .lvl_q     (lvl_q)
);

// File: tb/bidir_gpio_port_tb_top.sv
module bidir_gpio_port_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;
   localparam int ADDR_W     = 2;

   typedef struct {
      logic [W-1:0] data;
      string        tag;
   } exp_item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [W-1:0]      bus_wdata = '0;
   logic [W-1:0]      bus_rdata;
   logic [W-1:0]      pad_in = '0;
   logic              pullup_off = 1'b0;
   logic              sleep_req = 1'b0;
   logic [W-1:0]      pad_oe;
   logic [W-1:0]      pad_out;
   logic [W-1:0]      pad_pu;

   int        n_checks = 0;
   int        n_errors = 0;
   exp_item_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   bidir_gpio_port dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pullup_off(pullup_off),
      .sleep_req (sleep_req),
      .pad_oe    (pad_oe),
      .pad_out   (pad_out),
      .pad_pu    (pad_pu)
   );

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic check_pads(input string tag, input logic [W-1:0] oe,
                             input logic [W-1:0] dout, input logic [W-1:0] pu);
      check({tag, " oe"}, pad_oe, oe);
      check({tag, " out"}, pad_out, dout);
      check({tag, " pu"}, pad_pu, pu);
   endtask

   // driver: register write, outputs settle after the edge inside the two negedges
   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      #2;
   endtask

   // driver: register read, expected value goes to the scoreboard
   task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [W-1:0] exp, input string tag);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      sb_q.push_back('{data: exp, tag: tag});
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // monitor: compares every read cycle against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (bus_rd) begin
            if (sb_q.size() == 0) begin
               check("scoreboard underflow", bus_rdata, 'x);
            end else begin
               exp_item_t it;
               it = sb_q.pop_front();
               check(it.tag, bus_rdata, it.data);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      // R1: pads idle while reset is held
      #3;
      check_pads("R1 in reset", 8'h00, 8'h00, 8'h00);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      bus_read(2'd1, 8'h00, "R1 dir after reset");
      bus_read(2'd2, 8'h00, "R1 lvl after reset");
      bus_read(2'd0, 8'h00, "R1 pin after reset");

      // R2: direction
      bus_write(2'd1, 8'hF0);
      check_pads("R2 dir F0", 8'hF0, 8'h00, 8'h00);
      bus_read(2'd1, 8'hF0, "R2 dir readback");

      // R3/R4: level drives outputs, pulls up inputs
      bus_write(2'd2, 8'hA5);
      check_pads("R3 R4 lvl A5", 8'hF0, 8'hA0, 8'h05);
      bus_read(2'd2, 8'hA5, "R3 lvl readback");

      // R5: global pull-up disable
      @(negedge clk); pullup_off = 1'b1; #2;
      check("R5 pu forced off", pad_pu, 8'h00);
      @(negedge clk); pullup_off = 1'b0; #2;
      check("R4 pu restored", pad_pu, 8'h05);

      // R8: toggle through the pin address
      bus_write(2'd0, 8'h0F);
      check_pads("R8 toggle", 8'hF0, 8'hA0, 8'h0A);
      bus_read(2'd2, 8'hAA, "R8 lvl after toggle");
      bus_write(2'd0, 8'hFF);
      bus_read(2'd2, 8'h55, "R8 lvl full invert");
      check_pads("R8 full invert", 8'hF0, 8'h50, 8'h05);

      // R6: two-edge input latency, stepped read
      @(negedge clk);
      pad_in = 8'h3C; bus_rd = 1'b1; bus_addr = 2'd0;
      sb_q.push_back('{data: 8'h00, tag: "R6 before edge"});
      @(negedge clk);
      sb_q.push_back('{data: 8'h00, tag: "R6 after one edge"});
      @(negedge clk);
      sb_q.push_back('{data: 8'h3C, tag: "R6 after two edges"});
      @(negedge clk);
      pad_in = 8'hC3;
      sb_q.push_back('{data: 8'h3C, tag: "R6 second pattern hold"});
      @(negedge clk);
      sb_q.push_back('{data: 8'h3C, tag: "R6 second pattern one edge"});
      @(negedge clk);
      sb_q.push_back('{data: 8'hC3, tag: "R6 second pattern two edges"});
      @(negedge clk);
      bus_rd = 1'b0;

      // R7: sleep clamps the input path
      @(negedge clk); sleep_req = 1'b1;
      repeat (3) @(negedge clk);
      bus_read(2'd0, 8'h00, "R7 sleep clamp");
      @(negedge clk); sleep_req = 1'b0;
      repeat (3) @(negedge clk);
      bus_read(2'd0, 8'hC3, "R7 wake");

      // R9: unmapped address and idle read
      bus_write(2'd3, 8'hFF);
      bus_read(2'd1, 8'hF0, "R9 dir untouched");
      bus_read(2'd2, 8'h55, "R9 lvl untouched");
      bus_read(2'd3, 8'h00, "R9 unmapped read");
      @(negedge clk); bus_addr = 2'd1; #2;
      check("R9 rdata idle", bus_rdata, 8'h00);

      // R1: asynchronous reset between edges
      bus_write(2'd1, 8'hFF);
      check_pads("R1 pre-reset", 8'hFF, 8'h55, 8'h00);
      @(posedge clk); #(CLK_PERIOD/4);
      rst_n = 1'b0; #1;
      check_pads("R1 async reset", 8'h00, 8'h00, 8'h00);
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      bus_read(2'd1, 8'h00, "R1 dir cleared");
      bus_read(2'd2, 8'h00, "R1 lvl cleared");

      repeat (2) @(negedge clk);
      if (sb_q.size() != 0) check("scoreboard leftover", W'(sb_q.size()), 8'h00);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule